// File: doc/BRIEF.md
# Open-Collector Serial Bus Byte Listener

This block is the receiving end of a two-wire, open-collector byte transfer bus that uses a clock wire and a data wire. The sender owns the clock wire. The data wire is shared: between bytes the receivers drive it, and while bits are moving the sender drives it. The listener holds the data wire while it has no room for a byte. It lets go of the wire once its consumer has taken the last byte and the sender has released the clock wire. It then measures how long the sender waits before asserting the clock wire again. That pause tells it whether the coming byte is an ordinary one, the final byte of a stream, or whether the stream is empty. After a final-byte pause the listener answers with a timed pulse on the data wire. It then samples eight bits, least significant first, one per clock-released window, and reasserts the data wire as soon as the eighth bit is in.

Each result goes to a local consumer as a byte with valid and ready signals, plus two qualifiers: one marks the last byte of a stream, the other marks an empty stream. The bus inputs and the pull output use asserted-high logic: 1 means the wire is pulled. The pad logic around the block does the wired-OR and the electrical inversion. All bus timing is counted in microsecond ticks. `TICK_DIV` sets how many core clocks make one tick.

The controller has seven states. `ST_BUSY` holds the data wire and moves to `ST_LISTEN` once the clock wire reads released. `ST_LISTEN` releases the data wire and runs the pause timer. If the clock wire is asserted first it moves to `ST_BIT_SETUP`; when the timer reaches the last-byte threshold it moves to `ST_EOI_ACK`. `ST_EOI_ACK` pulls the data wire for the acknowledge time and then moves to `ST_EOI_WAIT`. From `ST_EOI_WAIT`, a clock-wire assertion leads to `ST_BIT_SETUP` with the last-byte mark set, and reaching the empty threshold leads to `ST_HOLD` with the empty mark set. `ST_BIT_SETUP` waits for the clock wire to be released and then enters `ST_BIT_VALID`. `ST_BIT_VALID` shifts in one bit on the clock-assert edge. It returns to `ST_BIT_SETUP`, or goes to `ST_HOLD` after the eighth bit. `ST_HOLD` presents the result while holding the data wire and returns to `ST_BUSY` on the consumer handshake.

Top module: `serbus_listener`

## Requirements
- R1: After reset, and whenever no result is waiting for the consumer, `data_pull_o` stays 1 for as long as `bus_clk_i` reads 1. It drops to 0 once `bus_clk_i` reads 0, which signals readiness.
- R2: If `bus_clk_i` rises less than `EOI_US` (256) ticks after the data wire is released, the byte is ordinary. No pulse appears on `data_pull_o` during the pause, and the result has `out_eoi_o`=0 and `out_empty_o`=0.
- R3: If `bus_clk_i` is still 0 `EOI_US` ticks after release, `data_pull_o` goes to 1 for `ACK_US` (60) ticks and then back to 0. The byte that follows is delivered with `out_eoi_o`=1.
- R4: If `bus_clk_i` is still 0 `EMPTY_US` (512) ticks after release, no bits are taken. The result is delivered with `out_empty_o`=1, `out_eoi_o`=0 and `out_byte_o`=0.
- R5: Bits arrive least significant first, one per window in which `bus_clk_i` reads 0. A data wire that reads released (0) in the window gives bit value 1, and one that reads pulled (1) gives 0.
- R6: Each bit is the data-wire level seen just before the clock-assert edge, so a sender that changes the data wire in the same cycle it asserts the clock wire does not corrupt the bit.
- R7: `data_pull_o` rises within 100 ticks after the eighth bit (in practice within a few core clocks) and stays 1 while `out_valid_o` is 1.
- R8: `out_valid_o`, `out_byte_o`, `out_eoi_o` and `out_empty_o` hold steady until `out_ready_i` is 1, and `out_valid_o` falls in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Clock wire level, 1 = pulled by someone |
| bus_data_i | input | 1 | Data wire level, 1 = pulled by someone |
| out_ready_i | input | 1 | Consumer can take the result |
| data_pull_o | output | 1 | 1 = this block pulls the data wire |
| out_valid_o | output | 1 | Result available |
| out_byte_o | output | BYTE_W | Received byte (zero on empty stream) |
| out_eoi_o | output | 1 | Result is the last byte of the stream |
| out_empty_o | output | 1 | Stream was empty, no byte received |

## Verification
The assertions assume the consumer follows a valid/ready handshake. They also assume that sender and consumer never drive the block toward an output change while a result is waiting. The assertions therefore look only at the output handshake and at the data-wire pull during the wait, never at bus timing that an outside party controls. The stimulus stays inside those assumptions. A sender model asserts the clock wire only after it has seen the data wire released and, in last-byte mode, only after it has watched the full acknowledge pulse end. The consumer raises ready for exactly one cycle, and only once valid has been seen. Bit hold times are 20 and 60 ticks, well above the synchronizer latency, and the sender releases the data wire in the same cycle it asserts the clock wire.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    typedef enum logic [2:0] {
        ST_BUSY      = 3'd0,
        ST_LISTEN    = 3'd1,
        ST_EOI_ACK   = 3'd2,
        ST_EOI_WAIT  = 3'd3,
        ST_BIT_SETUP = 3'd4,
        ST_BIT_VALID = 3'd5,
        ST_HOLD      = 3'd6
    } sbl_state_e;

endpackage

// File: rtl/sbl_sync.sv
// Multi-stage synchronizer for asynchronous bus levels.
module sbl_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], in_i[g]};
        end
        assign out_o[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/sbl_ustimer.sv
// Microsecond tick prescaler with a saturating elapsed counter.
module sbl_ustimer #(
    parameter int TICK_DIV = 50,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic [CNT_W-1:0] us_o
);

    localparam int PW = $clog2(TICK_DIV + 1);
    localparam logic [PW-1:0] PRE_TOP = PW'(TICK_DIV - 1);

    logic [PW-1:0]    pre_q;
    logic [CNT_W-1:0] us_q;
    logic             tick;

    assign tick = (pre_q == PRE_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (!run_i) begin
            pre_q <= '0;
            us_q  <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick && (us_q != '1)) us_q <= us_q + 1'b1;
        end
    end

    assign us_o = us_q;

endmodule

// File: rtl/sbl_shifter.sv
// LSB-first deserializer with a bit counter.
module sbl_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o,
    output logic         last_o
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (shift_i) begin
            sr_q  <= {bit_i, sr_q[W-1:1]};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign data_o = sr_q;
    assign last_o = (cnt_q == LAST_IDX);

endmodule

// File: rtl/serbus_listener.sv
// Byte listener for an open-collector clock/data serial bus.
module serbus_listener
    import sbl_pkg::*;
#(
    parameter int TICK_DIV = 50,   // core clocks per microsecond tick
    parameter int EOI_US   = 256,  // pause that marks the last byte
    parameter int EMPTY_US = 512,  // pause that marks an empty stream
    parameter int ACK_US   = 60,   // last-byte acknowledge pulse width
    parameter int BYTE_W   = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk_i,
    input  logic              bus_data_i,
    input  logic              out_ready_i,
    output logic              data_pull_o,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic              out_eoi_o,
    output logic              out_empty_o
);

    localparam int CNT_W = $clog2(EMPTY_US + 1) + 1;
    localparam logic [CNT_W-1:0] EOI_LIM   = CNT_W'(EOI_US);
    localparam logic [CNT_W-1:0] ACK_LIM   = CNT_W'(EOI_US + ACK_US);
    localparam logic [CNT_W-1:0] EMPTY_LIM = CNT_W'(EMPTY_US);

    sbl_state_e state_q, state_d;

    logic [1:0]       sync_q;
    logic             clk_s, data_s;
    logic             clk_prev_q, data_prev_q;
    logic             clk_edge;
    logic [CNT_W-1:0] us_cnt;
    logic             timer_run;
    logic             sh_clear, sh_shift, sh_last;
    logic             eoi_q, empty_q;
    logic             set_eoi, set_empty;

    // Bus level synchronization (both wires reset to the pulled level)
    sbl_sync #(
        .W      (2),
        .STAGES (SYNC_STG),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .in_i ({bus_data_i, bus_clk_i}),
        .out_o(sync_q)
    );

    assign clk_s  = sync_q[0];
    assign data_s = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev_q  <= 1'b1;
            data_prev_q <= 1'b1;
        end else begin
            clk_prev_q  <= clk_s;
            data_prev_q <= data_s;
        end
    end

    // Clock wire being asserted closes the current valid window
    assign clk_edge = clk_s & ~clk_prev_q;

    sbl_ustimer #(
        .TICK_DIV(TICK_DIV),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run_i(timer_run),
        .us_o (us_cnt)
    );

    // A released data wire in the window carries a one
    sbl_shifter #(
        .W(BYTE_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(sh_clear),
        .shift_i(sh_shift),
        .bit_i  (~data_prev_q),
        .data_o (out_byte_o),
        .last_o (sh_last)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        set_eoi   = 1'b0;
        set_empty = 1'b0;
        unique case (state_q)
            ST_BUSY: begin
                if (!clk_s) state_d = ST_LISTEN;
            end
            ST_LISTEN: begin
                if (clk_s)                  state_d = ST_BIT_SETUP;
                else if (us_cnt >= EOI_LIM) state_d = ST_EOI_ACK;
            end
            ST_EOI_ACK: begin
                if (us_cnt >= ACK_LIM) state_d = ST_EOI_WAIT;
            end
            ST_EOI_WAIT: begin
                if (clk_s) begin
                    state_d = ST_BIT_SETUP;
                    set_eoi = 1'b1;
                end else if (us_cnt >= EMPTY_LIM) begin
                    state_d   = ST_HOLD;
                    set_empty = 1'b1;
                end
            end
            ST_BIT_SETUP: begin
                if (!clk_s) state_d = ST_BIT_VALID;
            end
            ST_BIT_VALID: begin
                if (clk_edge) state_d = sh_last ? ST_HOLD : ST_BIT_SETUP;
            end
            ST_HOLD: begin
                if (out_ready_i) state_d = ST_BUSY;
            end
            default: state_d = ST_BUSY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BUSY;
        else        state_q <= state_d;
    end

    // Stream qualifier flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoi_q   <= 1'b0;
            empty_q <= 1'b0;
        end else if (state_q == ST_LISTEN) begin
            eoi_q   <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            if (set_eoi)   eoi_q   <= 1'b1;
            if (set_empty) empty_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        data_pull_o = 1'b0;
        out_valid_o = 1'b0;
        timer_run   = 1'b0;
        sh_clear    = 1'b0;
        sh_shift    = 1'b0;
        unique case (state_q)
            ST_BUSY:      data_pull_o = 1'b1;
            ST_LISTEN: begin
                timer_run = 1'b1;
                sh_clear  = 1'b1;
            end
            ST_EOI_ACK: begin
                data_pull_o = 1'b1;
                timer_run   = 1'b1;
            end
            ST_EOI_WAIT:  timer_run = 1'b1;
            ST_BIT_SETUP: ;
            ST_BIT_VALID: sh_shift = clk_edge;
            ST_HOLD: begin
                data_pull_o = 1'b1;
                out_valid_o = 1'b1;
            end
            default:      data_pull_o = 1'b1;
        endcase
    end

    assign out_eoi_o   = eoi_q;
    assign out_empty_o = empty_q;

endmodule

// File: rtl/serbus_listener_chk.sv
// Property checker for the serial bus listener.
module serbus_listener_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_ready_i,
    input logic              data_pull_o,
    input logic              out_valid_o,
    input logic [BYTE_W-1:0] out_byte_o,
    input logic              out_eoi_o,
    input logic              out_empty_o
);

    p_busy_while_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> data_pull_o);

    p_result_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_byte_o) && $stable(out_eoi_o) && $stable(out_empty_o)));

    p_drop_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i) |=> !out_valid_o);

    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !(out_eoi_o && out_empty_o));

    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_empty_o) |-> (out_byte_o == '0));

endmodule

bind serbus_listener serbus_listener_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_ready_i(out_ready_i),
    .data_pull_o(data_pull_o),
    .out_valid_o(out_valid_o),
    .out_byte_o (out_byte_o),
    .out_eoi_o  (out_eoi_o),
    .out_empty_o(out_empty_o)
);

// File: tb/serbus_listener_tb_top.sv
module serbus_listener_tb_top;

    localparam int TICK     = 10;
    localparam int EOI_US   = 256;
    localparam int EMPTY_US = 512;
    localparam int ACK_US   = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snd_clk = 1'b1;
    logic       snd_data = 1'b0;
    logic       ready = 1'b0;
    logic       data_pull;
    logic       valid;
    logic [7:0] rx_byte;
    logic       eoi, empty;
    logic       bus_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign bus_data = snd_data | data_pull;

    serbus_listener #(
        .TICK_DIV(TICK), .EOI_US(EOI_US), .EMPTY_US(EMPTY_US), .ACK_US(ACK_US)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_clk_i(snd_clk), .bus_data_i(bus_data), .out_ready_i(ready),
        .data_pull_o(data_pull), .out_valid_o(valid), .out_byte_o(rx_byte),
        .out_eoi_o(eoi), .out_empty_o(empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_us(input int us);
        repeat (us * TICK) @(negedge clk);
    endtask

    // Wait for the data wire to read released; returns cycles waited
    task automatic wait_data_level(input logic lvl, input int max_us, output int cyc);
        cyc = 0;
        while (bus_data !== lvl && cyc < max_us * TICK) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // Sender model: releases clock wire, waits for readiness, then sends
    task automatic send_byte(input logic [7:0] b, input int pre_us, input int hold_us,
                             input bit last);
        int  cyc;
        bit  saw_pull;
        @(negedge clk);
        snd_clk = 1'b0;
        wait_data_level(1'b0, 2000, cyc);
        chk(bus_data == 1'b0, "R1 release", bus_data, 0);
        if (last) begin
            wait_data_level(1'b1, 400, cyc);
            chk(cyc >= (EOI_US - 4) * TICK && cyc <= (EOI_US + 4) * TICK,
                "R3 ack start", cyc, EOI_US * TICK);
            wait_data_level(1'b0, 200, cyc);
            chk(cyc >= (ACK_US * TICK) - 4 && cyc <= (ACK_US + 2) * TICK,
                "R3 ack width", cyc, ACK_US * TICK);
            wait_us(10);
        end else begin
            saw_pull = 1'b0;
            for (int i = 0; i < pre_us * TICK; i++) begin
                @(negedge clk);
                if (bus_data) saw_pull = 1'b1;
            end
            chk(!saw_pull, "R2 no pulse", saw_pull, 0);
        end
        snd_clk = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_us(hold_us);
            snd_data = ~b[i];          // released wire carries a one (R5)
            wait_us(2);
            snd_clk = 1'b0;            // valid window
            wait_us(hold_us);
            snd_clk = 1'b1;            // data changes with the edge (R6)
            snd_data = 1'b0;
        end
        wait_us(5);
        chk(bus_data == 1'b1, "R7 busy after byte", bus_data, 1);
    endtask

    task automatic expect_result(input logic [7:0] b, input logic e_eoi,
                                 input logic e_empty, input string req);
        chk(valid == 1'b1, {req, " valid"}, valid, 1);
        chk(rx_byte == b, {req, " byte"}, rx_byte, b);
        chk(eoi == e_eoi, {req, " eoi"}, eoi, e_eoi);
        chk(empty == e_empty, {req, " empty"}, empty, e_empty);
    endtask

    task automatic accept;
        @(negedge clk);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        @(negedge clk);
        chk(valid == 1'b0, "R8 drop after accept", valid, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_us(20);
        chk(data_pull == 1'b1, "R1 reset pull", data_pull, 1);
        chk(valid == 1'b0, "R1 reset valid", valid, 0);
    endtask

    task automatic t_normal;
        send_byte(8'hA5, 100, 20, 1'b0);
        expect_result(8'hA5, 1'b0, 1'b0, "R2 R5 normal");
        accept();
    endtask

    task automatic t_patterns;
        logic [7:0] pats [4] = '{8'h01, 8'h80, 8'h00, 8'hFF};
        for (int i = 0; i < 4; i++) begin
            send_byte(pats[i], 30, (i == 2) ? 60 : 20, 1'b0);
            expect_result(pats[i], 1'b0, 1'b0, "R5 R6 pattern");
            accept();
        end
    endtask

    task automatic t_near_boundary;
        send_byte(8'h5A, EOI_US - 16, 20, 1'b0);
        expect_result(8'h5A, 1'b0, 1'b0, "R2 near boundary");
        accept();
    endtask

    task automatic t_eoi;
        send_byte(8'h3C, 0, 20, 1'b1);
        expect_result(8'h3C, 1'b1, 1'b0, "R3 last byte");
        accept();
    endtask

    task automatic t_empty;
        int cyc, t;
        @(negedge clk);
        snd_clk = 1'b0;
        wait_data_level(1'b0, 2000, cyc);
        t = 0;
        while (!valid && t < 700 * TICK) begin
            @(negedge clk);
            t++;
        end
        chk(t >= (EMPTY_US - 2) * TICK && t <= (EMPTY_US + 10) * TICK,
            "R4 empty timing", t, EMPTY_US * TICK);
        expect_result(8'h00, 1'b0, 1'b1, "R4 empty");
        chk(bus_data == 1'b1, "R7 busy on empty", bus_data, 1);
        snd_clk = 1'b1;
        accept();
    endtask

    task automatic t_backpressure;
        send_byte(8'hC3, 50, 20, 1'b0);
        snd_clk = 1'b0;              // sender ready again, consumer is not
        wait_us(300);
        chk(bus_data == 1'b1, "R7 hold DATA", bus_data, 1);
        expect_result(8'hC3, 1'b0, 1'b0, "R8 held result");
        accept();
        wait_us(5);
        chk(bus_data == 1'b0, "R1 release after accept", bus_data, 0);
        send_byte(8'h96, 60, 20, 1'b0);
        expect_result(8'h96, 1'b0, 1'b0, "R8 next byte");
        accept();
    endtask

    task automatic t_clk_held;
        snd_clk = 1'b1;
        wait_us(300);
        chk(bus_data == 1'b1, "R1 wait for clock release", bus_data, 1);
        send_byte(8'h69, 80, 20, 1'b0);
        expect_result(8'h69, 1'b0, 1'b0, "R1 after hold");
        accept();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_patterns();
        t_near_boundary();
        t_eoi();
        t_empty();
        t_backpressure();
        t_clk_held();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule